// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time in packed BCD registers and presents them, together with a small general-purpose RAM, through a byte-wide port with an auto-incrementing pointer. A free-running input tick drives a prescaler. Each time the prescaler completes a count of `DIV` ticks, one second is added. The carry then ripples through minutes, hours, day of week, date, month and year. Hours can be kept in 24-hour form or in 12-hour form with an AM/PM flag. The end-of-month rollover follows the month and a four-year leap rule.

Bus logic outside the block loads the pointer with `ptr_load`. Each `wr_en` or `rd_en` access then touches the byte at the pointer and moves the pointer on by one. `rd_data` always shows the byte at the current pointer. The control register drives three outputs: a static output level, a square-wave enable and a rate select. The square-wave generator that uses these outputs is outside the block.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the pointer is 0x00 and the clock bytes read seconds 0x80 (halted), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00 and control 0x00. The RAM reads 0x00 and all outputs are 0.
- R2: `ptr_load` loads `ptr_val` into the pointer and blocks any access in that cycle. Otherwise each `wr_en` or `rd_en` cycle advances the pointer by one, and the pointer wraps from 0x3F to 0x00. `rd_data` shows the byte at the pointer, and a write goes to that byte.
- R3: Written clock bytes read back with their unused bits held at 0. The masks are minutes 0x7F, hours 0x7F, day 0x07, date 0x3F, month 0x1F and control 0x93. Seconds and year keep all 8 bits, and RAM at 0x08-0x3F keeps full bytes.
- R4: While seconds bit 7 is 0, every `DIV` cycles with `tick` high add one second. The whole calendar counts in BCD, with seconds at 0x00 (ones in bits 3-0, tens in bits 6-4) and the other fields at their own addresses.
- R5: While seconds bit 7 (halt) is 1, ticks change neither the time nor the prescaler.
- R6: Seconds and minutes roll over from 59 to 00 and carry into the next field.
- R7: In 24-hour mode (hours bit 6 = 0, tens in bits 5-4), hours go from 23 to 00 and the carry advances the day.
- R8: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, tens in bit 4), the hour goes from 11 to 12 and toggles PM, and from 12 to 01. Only the step from 11 PM to 12 AM advances the day.
- R9: Day of week (address 0x03) runs 1 to 7 and wraps to 1.
- R10: The date (0x04) wraps to 01 after day 28, 29, 30 or 31, chosen by the month (0x05) and by whether the year (0x06) is divisible by 4. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R11: A write to seconds clears the prescaler and drops any second that has become due but has not yet been applied.
- R12: A second that falls due during a write cycle is applied in the next cycle without a write. It is neither lost nor allowed to collide with the write.
- R13: `out_level` reflects control bit 7, `sqw_en` bit 4, and `sqw_rate` bits 1-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler input pulse, one count per high cycle |
| ptr_load | input | 1 | Load the register pointer |
| ptr_val | input | 6 | New pointer value |
| wr_en | input | 1 | Write `wr_data` at the pointer, then advance it |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read access: advance the pointer |
| rd_data | output | 8 | Byte at the current pointer |
| out_level | output | 1 | Static output level from control |
| sqw_en | output | 1 | Square-wave enable from control |
| sqw_rate | output | 2 | Square-wave rate select from control |

## Verification
The bench builds the block with `DIV` = 4, so that a second costs only four tick cycles. With seconds so cheap, every rollover stays within reach: 59 to 00, midnight in both hour formats, month ends in leap and common years, and the turn of the century. Random start times are biased toward these edges. Directed cases cover the rollovers, the halt bit, the prescaler clear and a second that falls due during a write.

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
  parameter int unsigned DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ptr_load,
  input  logic [5:0] ptr_val,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       out_level,
  output logic       sqw_en,
  output logic [1:0] sqw_rate
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] PRE_TOP = CW'(DIV - 1);

  logic [CW-1:0] pre_cnt;
  logic          pend;
  logic [5:0]    ptr;
  logic [7:0]    sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q, ctl_q;
  logic [7:0]    ram [8:63];

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic wr_act, sec_wr, step;
  assign wr_act = wr_en && !ptr_load;
  assign sec_wr = wr_act && (ptr == 6'd0);
  assign step   = pend && !wr_act;

  logic [6:0] yr_bin;
  logic       leap;
  logic [7:0] last_day;
  assign yr_bin = {3'b0, yr_q[7:4]} * 7'd10 + {3'b0, yr_q[3:0]};
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n, h5_inc;

  assign c_min  = sec_q[6:0] >= 7'h59;
  assign sec_n  = c_min ? 8'h00 : bcd_inc(sec_q);
  assign c_hr   = c_min && (min_q[6:0] >= 7'h59);
  assign min_n  = (min_q[6:0] >= 7'h59) ? 8'h00 : bcd_inc(min_q);
  assign h5_inc = bcd_inc({3'b0, hr_q[4:0]});

  always_comb begin
    if (!hr_q[6]) begin
      c_day = c_hr && (hr_q[5:0] >= 6'h23);
      hr_n  = (hr_q[5:0] >= 6'h23) ? 8'h00 : bcd_inc(hr_q);
    end else if (hr_q[4:0] == 5'h11) begin
      c_day = c_hr && hr_q[5];
      hr_n  = {2'b01, ~hr_q[5], 5'h12};
    end else if (hr_q[4:0] >= 5'h12) begin
      c_day = 1'b0;
      hr_n  = {2'b01, hr_q[5], 5'h01};
    end else begin
      c_day = 1'b0;
      hr_n  = {2'b01, hr_q[5], h5_inc[4:0]};
    end
  end

  assign dow_n  = (dow_q[2:0] >= 3'd7) ? 8'h01 : dow_q + 8'd1;
  assign c_mon  = c_day && (date_q >= last_day);
  assign date_n = (date_q >= last_day) ? 8'h01 : bcd_inc(date_q);
  assign c_yr   = c_mon && (mon_q >= 8'h12);
  assign mon_n  = (mon_q >= 8'h12) ? 8'h01 : bcd_inc(mon_q);
  assign yr_n   = (yr_q >= 8'h99) ? 8'h00 : bcd_inc(yr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pend    <= 1'b0;
      ptr     <= 6'd0;
      sec_q   <= 8'h80;
      min_q   <= 8'h00;
      hr_q    <= 8'h00;
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      mon_q   <= 8'h01;
      yr_q    <= 8'h00;
      ctl_q   <= 8'h00;
      for (int i = 8; i < 64; i++) ram[i] <= 8'h00;
    end else begin
      if (sec_wr) begin
        pre_cnt <= '0;
        pend    <= 1'b0;
      end else begin
        if (step) pend <= 1'b0;
        if (tick && !sec_q[7]) begin
          if (pre_cnt == PRE_TOP) begin
            pre_cnt <= '0;
            pend    <= 1'b1;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
      end

      if (step) begin
        sec_q <= sec_n;
        if (c_min) min_q <= min_n;
        if (c_hr)  hr_q  <= hr_n;
        if (c_day) begin
          dow_q  <= dow_n;
          date_q <= date_n;
        end
        if (c_mon) mon_q <= mon_n;
        if (c_yr)  yr_q  <= yr_n;
      end

      if (wr_act) begin
        case (ptr)
          6'd0:    sec_q  <= wr_data;
          6'd1:    min_q  <= wr_data & 8'h7F;
          6'd2:    hr_q   <= wr_data & 8'h7F;
          6'd3:    dow_q  <= wr_data & 8'h07;
          6'd4:    date_q <= wr_data & 8'h3F;
          6'd5:    mon_q  <= wr_data & 8'h1F;
          6'd6:    yr_q   <= wr_data;
          6'd7:    ctl_q  <= wr_data & 8'h93;
          default: ram[ptr] <= wr_data;
        endcase
      end

      if (ptr_load)              ptr <= ptr_val;
      else if (wr_en || rd_en)   ptr <= ptr + 6'd1;
    end
  end

  always_comb begin
    case (ptr)
      6'd0:    rd_data = sec_q;
      6'd1:    rd_data = min_q;
      6'd2:    rd_data = hr_q;
      6'd3:    rd_data = dow_q;
      6'd4:    rd_data = date_q;
      6'd5:    rd_data = mon_q;
      6'd6:    rd_data = yr_q;
      6'd7:    rd_data = ctl_q;
      default: rd_data = ram[ptr];
    endcase
  end

  assign out_level = ctl_q[7];
  assign sqw_en    = ctl_q[4];
  assign sqw_rate  = ctl_q[1:0];
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ptr_load,
  input logic       wr_en,
  input logic       rd_en,
  input logic [5:0] ptr,
  input logic [7:0] sec_q,
  input logic       pre_zero,
  input logic       pend
);
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_load && (wr_en || rd_en)) |=> (ptr == $past(ptr) + 6'd1));

  a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[7] && !(wr_en && !ptr_load && ptr == 6'd0)) |=> $stable(sec_q));

  a_r11_prescale_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && ptr == 6'd0) |=> (pre_zero && !pend));

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && ptr != 6'd0) |=> $stable(sec_q));
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ptr_load (ptr_load),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .ptr      (ptr),
  .sec_q    (sec_q),
  .pre_zero (pre_cnt == '0),
  .pend     (pend)
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, ptr_load = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] ptr_val = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       out_level, sqw_en;
  logic [1:0] sqw_rate;

  int nvec = 0, nbad = 0;
  int m_sec, m_min, m_hr, m_f12, m_dow, m_date, m_mon, m_yr;

  rtc_regbank #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .out_level(out_level), .sqw_en(sqw_en), .sqw_rate(sqw_rate));

  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    case (mo)
      2:           return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  function automatic logic [7:0] hr_byte();
    logic [7:0] b;
    int h12;
    if (m_f12 == 0) return tobcd(m_hr);
    h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
    b = tobcd(h12);
    return {1'b0, 1'b1, (m_hr >= 12), b[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic set_ptr(input logic [5:0] a);
    @(negedge clk); ptr_load = 1'b1; ptr_val = a;
    @(posedge clk); @(negedge clk); ptr_load = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rd_data;
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv_model();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin
      m_min = 0; m_hr++;
      if (m_hr == 24) begin
        m_hr = 0;
        m_dow = (m_dow % 7) + 1;
        m_date++;
        if (m_date > dim(m_mon, m_yr)) begin
          m_date = 1; m_mon++;
          if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end
      end
    end
  endtask

  task automatic write_time();
    set_ptr(6'd0);
    wr(tobcd(m_sec)); wr(tobcd(m_min)); wr(hr_byte()); wr(8'(m_dow));
    wr(tobcd(m_date)); wr(tobcd(m_mon)); wr(tobcd(m_yr));
  endtask

  task automatic compare_time(input string tag);
    logic [7:0] v;
    set_ptr(6'd0);
    rd(v); chk({tag, " sec"}, v, tobcd(m_sec));
    rd(v); chk({tag, " min"}, v, tobcd(m_min));
    rd(v); chk({tag, " hr"},  v, hr_byte());
    rd(v); chk({tag, " dow"}, v, 8'(m_dow));
    rd(v); chk({tag, " date"}, v, tobcd(m_date));
    rd(v); chk({tag, " mon"}, v, tobcd(m_mon));
    rd(v); chk({tag, " yr"},  v, tobcd(m_yr));
  endtask

  task automatic run_case(input string tag, input int s, input int mi, input int h, input int f,
                          input int dw, input int dt, input int mo, input int y, input int n);
    m_sec = s; m_min = mi; m_hr = h; m_f12 = f; m_dow = dw; m_date = dt; m_mon = mo; m_yr = y;
    write_time();
    for (int i = 0; i < n; i++) begin
      ticks(DIV);
      adv_model();
    end
    compare_time(tag);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] exp_rst [8];
    logic [7:0] exp_msk [8];
    void'($urandom(32'd2024));
    exp_rst = '{8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    exp_msk = '{8'hFF, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'h93};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_level", {7'b0, out_level}, 8'h00);
    chk("R1 sqw_en", {7'b0, sqw_en}, 8'h00);
    chk("R1 rd_data at ptr 0", rd_data, 8'h80);
    for (int i = 0; i < 8; i++) begin rd(v); chk("R1 clock byte", v, exp_rst[i]); end
    rd(v); chk("R1 ram 0x08", v, 8'h00);

    // R3 masks, R13 outputs
    set_ptr(6'd0);
    for (int i = 0; i < 8; i++) wr(8'hFF);
    chk("R13 out_level", {7'b0, out_level}, 8'h01);
    chk("R13 sqw_en", {7'b0, sqw_en}, 8'h01);
    chk("R13 sqw_rate", {6'b0, sqw_rate}, 8'h03);
    set_ptr(6'd0);
    for (int i = 0; i < 8; i++) begin rd(v); chk("R3 masked readback", v, exp_msk[i]); end
    set_ptr(6'd7); wr(8'h12);
    chk("R13 out_level low", {7'b0, out_level}, 8'h00);
    chk("R13 sqw_en set", {7'b0, sqw_en}, 8'h01);
    chk("R13 sqw_rate 2", {6'b0, sqw_rate}, 8'h02);

    // R5 halt holds time and prescaler
    set_ptr(6'd0); wr(8'h80);
    ticks(3 * DIV);
    set_ptr(6'd0); rd(v); chk("R5 halted seconds", v, 8'h80);
    set_ptr(6'd0); wr(8'h00);
    ticks(DIV);
    set_ptr(6'd0); rd(v); chk("R5 running after clear", v, 8'h01);

    // R2 pointer wrap and RAM
    set_ptr(6'h3E); wr(8'hA5); wr(8'h5A); wr(8'h80);
    set_ptr(6'h3E);
    rd(v); chk("R2 ram 0x3E", v, 8'hA5);
    rd(v); chk("R2 ram 0x3F", v, 8'h5A);
    rd(v); chk("R2 wrap to 0x00", v, 8'h80);
    for (int k = 0; k < 10; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = 6'(8 + $urandom_range(0, 55));
      d = 8'($urandom);
      set_ptr(a); wr(d);
      set_ptr(a); rd(v); chk("R3 ram full byte", v, d);
    end

    // R6..R10 directed rollovers
    run_case("R6 sec roll", 59, 10, 5, 0, 2, 10, 3, 20, 1);
    run_case("R6 min roll", 59, 59, 5, 0, 2, 10, 3, 20, 1);
    run_case("R7 midnight 24h", 59, 59, 23, 0, 3, 15, 6, 5, 1);
    run_case("R8 11AM to 12PM", 59, 59, 11, 1, 3, 15, 6, 5, 1);
    run_case("R8 11PM to 12AM", 59, 59, 23, 1, 3, 15, 6, 5, 1);
    run_case("R8 12PM to 1PM", 59, 59, 12, 1, 3, 15, 6, 5, 1);
    run_case("R8 12AM to 1AM", 59, 59, 0, 1, 3, 15, 6, 5, 1);
    run_case("R9 dow wrap", 59, 59, 23, 0, 7, 15, 6, 5, 1);
    run_case("R10 Feb28 leap", 59, 59, 23, 0, 1, 28, 2, 24, 1);
    run_case("R10 Feb29 leap", 59, 59, 23, 0, 1, 29, 2, 24, 1);
    run_case("R10 Feb28 common", 59, 59, 23, 0, 1, 28, 2, 23, 1);
    run_case("R10 Apr30", 59, 59, 23, 0, 1, 30, 4, 23, 1);
    run_case("R10 Jan31", 59, 59, 23, 0, 1, 31, 1, 23, 1);
    run_case("R10 century", 59, 59, 23, 1, 7, 31, 12, 99, 1);

    // R11 seconds write clears prescaler
    m_sec = 16; m_min = 0; m_hr = 1; m_f12 = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 1;
    write_time();
    ticks(DIV - 1);
    m_sec = 20;
    set_ptr(6'd0); wr(tobcd(m_sec));
    ticks(DIV - 1);
    compare_time("R11 no advance after clear");
    ticks(1); adv_model();
    compare_time("R11 advance after full count");

    // R12 second due during a write to minutes
    m_sec = 59; m_min = 10; m_hr = 5; m_f12 = 0; m_dow = 4; m_date = 9; m_mon = 9; m_yr = 9;
    write_time();
    set_ptr(6'd1);
    @(negedge clk); tick = 1'b1;
    repeat (DIV) @(posedge clk);
    @(negedge clk); tick = 1'b0; wr_en = 1'b1; wr_data = 8'h59;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    repeat (2) @(posedge clk);
    m_min = 59; adv_model();
    compare_time("R12 deferred second");

    // R4 random calendar stepping
    for (int k = 0; k < 60; k++) begin
      int s, mi, h, f, dw, mo, y, dt, n, pick;
      s  = 55 + $urandom_range(0, 4);
      mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      pick = $urandom_range(0, 4);
      h  = (pick == 0) ? 11 : (pick == 1) ? 12 : (pick == 2) ? 23 : (pick == 3) ? 0 : $urandom_range(0, 23);
      f  = $urandom_range(0, 1);
      dw = $urandom_range(1, 7);
      mo = $urandom_range(1, 12);
      pick = $urandom_range(0, 4);
      y  = (pick == 0) ? 23 : (pick == 1) ? 24 : (pick == 2) ? 99 : (pick == 3) ? 0 : $urandom_range(0, 99);
      dt = ($urandom_range(0, 1) == 1) ? dim(mo, y) : $urandom_range(1, dim(mo, y));
      n  = $urandom_range(1, 6);
      run_case("R4 random", s, mi, h, f, dw, dt, mo, y, n);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule